// File: doc/BRIEF.md
# Rotor Lock Supervisor

This block watches a sensorless three-phase motor controller for signs that the rotor has stopped turning, or never turned, while it is being driven. It runs six independent checks. Each check has its own arming condition. When any armed check trips, the block emits a one-cycle lock pulse and records which check caused it. It then holds the power stage in high impedance for a fixed wait. At the end of the wait it asks the controller to begin a new start attempt.

The estimators that produce its inputs lie outside this block and are read as plain digital values. Those inputs are the controller state, the phase-U current sampled at the end of alignment, the motor constant measured at handoff and the one tracked while running, the commutation rate and period, the back-EMF estimate and the applied phase-U voltage. All ratio tests are done with shifts, adds and compares, so the block needs no divider.

Top module: `lock_supervisor`

## Requirements
- R1: When `handoff` is high, a lock with cause code 1 fires if `kt_meas` is below 200. A value of exactly 200 passes.
- R2: When `align_done` is high, a lock with cause code 2 fires if `iu_ma` is 50 or less. A value of 51 passes.
- R3: While `ctl_state` is 2 (open loop), a lock with cause code 3 fires if `comm_freq` exceeds 200. A value of 200 passes. The check is not armed in state 3 (closed loop).
- R4: While `ctl_state` is 3, a lock with cause code 4 fires if `kt_run` falls outside the inclusive window from half to twice the `kt_meas` value captured at the last handoff. The check is blanked for BLANK_CYC cycles after the handoff.
- R5: While `ctl_state` is 3, a lock with cause code 5 fires on a `comm_strobe` whose `comm_per` is strictly less than half the period from the previous strobe. A period of exactly half passes.
- R6: Outside state 0 (idle), a lock with cause code 6 fires at an `elec_tick` if 2·`bemf` > 3·`vph_u` held on every cycle since the previous `elec_tick`, including the closing tick. A single cycle at or below the limit cancels that period, and the first tick after idle or lock never fires.
- R7: `lock_pulse` is high for one cycle, one cycle after the tripping inputs are sampled. `hiz_en` is then high for exactly RESTART_CYC cycles, and `restart_req` pulses for one cycle in the cycle after `hiz_en` falls.
- R8: `cause` holds its code while `hiz_en` is high and returns to 0 together with `restart_req`. If several checks trip in the same cycle, the lowest code wins.
- R9: While `hiz_en` is high, all checks are ignored: no new `lock_pulse` occurs and `cause` does not change.
- R10: After reset, `lock_pulse`, `cause`, `hiz_en` and `restart_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_state | input | 2 | 0 idle, 1 align, 2 open loop, 3 closed loop |
| align_done | input | 1 | One-cycle pulse at the end of alignment |
| iu_ma | input | IU_W | Phase-U current at the end of alignment, in mA |
| handoff | input | 1 | One-cycle pulse at the open-to-closed-loop handoff |
| kt_meas | input | KT_W | Motor constant measured at handoff, in mV/Hz |
| kt_run | input | KT_W | Motor constant tracked in closed loop, in mV/Hz |
| comm_freq | input | FQ_W | Commutation rate, in Hz |
| comm_strobe | input | 1 | Pulse marking a new `comm_per` value |
| comm_per | input | PER_W | Latest commutation period |
| bemf | input | V_W | Back-EMF estimate |
| vph_u | input | V_W | Applied phase-U voltage amplitude |
| elec_tick | input | 1 | Pulse at each electrical-period boundary |
| lock_pulse | output | 1 | One-cycle lock indication |
| cause | output | 3 | Code of the check that fired, or 0 |
| hiz_en | output | 1 | Phase outputs to high impedance |
| restart_req | output | 1 | One-cycle request for a new start attempt |

## Verification
The alignment-current check and the open-loop overspeed check can trip in the same cycle. The bench provokes this by pulsing `align_done` with zero current while it drives an open-loop rate of 201 Hz on that same edge. The scoreboard then expects exactly one lock, carrying code 2, followed by a normal high-impedance wait and restart. A second overlap occurs when a check trips during the wait itself. The bench keeps the overspeed condition and adds an alignment fault inside the wait, and it judges that neither one produces a pulse or alters the code.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int NCHK = 6;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ALIGN  = 2'd1,
    ST_OPEN   = 2'd2,
    ST_CLOSED = 2'd3
  } ctl_state_e;

  typedef enum logic [2:0] {
    CZ_NONE     = 3'd0,
    CZ_KT_LOW   = 3'd1,
    CZ_NO_MOTOR = 3'd2,
    CZ_OL_FAST  = 3'd3,
    CZ_KT_WIN   = 3'd4,
    CZ_PER_JUMP = 3'd5,
    CZ_BEMF_HI  = 3'd6
  } cause_e;
endpackage

// File: rtl/lock_blank_timer.sv
module lock_blank_timer #(
  parameter int BLANK_CYC = 75_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  output logic busy
);
  localparam int BW = (BLANK_CYC > 2) ? $clog2(BLANK_CYC) : 1;
  localparam logic [BW-1:0] LAST = BW'(BLANK_CYC - 1);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (clr) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_d = 1'b0;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  p_blank_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr) |=> busy);
endmodule

// File: rtl/lock_criteria.sv
module lock_criteria
  import lock_pkg::*;
#(
  parameter int KT_W        = 10,
  parameter int IU_W        = 10,
  parameter int FQ_W        = 12,
  parameter int PER_W       = 16,
  parameter int V_W         = 12,
  parameter int KT_MIN_MVHZ = 200,
  parameter int IU_MIN_MA   = 50,
  parameter int OL_MAX_HZ   = 200,
  parameter int BLANK_CYC   = 75_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [1:0]       ctl_state,
  input  logic             align_done,
  input  logic [IU_W-1:0]  iu_ma,
  input  logic             handoff,
  input  logic [KT_W-1:0]  kt_meas,
  input  logic [KT_W-1:0]  kt_run,
  input  logic [FQ_W-1:0]  comm_freq,
  input  logic             comm_strobe,
  input  logic [PER_W-1:0] comm_per,
  input  logic [V_W-1:0]   bemf,
  input  logic [V_W-1:0]   vph_u,
  input  logic             elec_tick,
  output logic [NCHK-1:0]  hit
);
  localparam logic [KT_W-1:0] KT_MIN = KT_W'(KT_MIN_MVHZ);
  localparam logic [IU_W-1:0] IU_MIN = IU_W'(IU_MIN_MA);
  localparam logic [FQ_W-1:0] OL_MAX = FQ_W'(OL_MAX_HZ);

  logic             st_open, st_closed, st_idle;
  logic             blank_busy;
  logic [KT_W-1:0]  kt_ref_q, kt_ref_d;
  logic             ref_vld_q, ref_vld_d;
  logic [PER_W-1:0] prev_q, prev_d;
  logic             prev_vld_q, prev_vld_d;
  logic             seg_on_q, seg_on_d, seg_ok_q, seg_ok_d;
  logic             over;
  logic [KT_W:0]    run_x2, ref_x2, run_x1, ref_x1;
  logic [V_W+1:0]   bemf_x2, vph_x3;

  assign st_open   = (ctl_state == ST_OPEN);
  assign st_closed = (ctl_state == ST_CLOSED);
  assign st_idle   = (ctl_state == ST_IDLE);

  lock_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .start (handoff && !hold),
    .clr   (hold),
    .busy  (blank_busy)
  );

  assign run_x2  = {kt_run, 1'b0};
  assign run_x1  = {1'b0, kt_run};
  assign ref_x2  = {kt_ref_q, 1'b0};
  assign ref_x1  = {1'b0, kt_ref_q};
  assign bemf_x2 = {1'b0, bemf, 1'b0};
  assign vph_x3  = {2'b00, vph_u} + {1'b0, vph_u, 1'b0};
  assign over    = (bemf_x2 > vph_x3);

  always_comb begin
    hit    = '0;
    hit[0] = handoff && (kt_meas < KT_MIN);
    hit[1] = align_done && (iu_ma <= IU_MIN);
    hit[2] = st_open && (comm_freq > OL_MAX);
    hit[3] = st_closed && ref_vld_q && !blank_busy && !handoff &&
             ((run_x2 < ref_x1) || (run_x1 > ref_x2));
    hit[4] = st_closed && comm_strobe && prev_vld_q &&
             ({comm_per, 1'b0} < {1'b0, prev_q});
    hit[5] = !st_idle && elec_tick && seg_on_q && seg_ok_q && over;
  end

  always_comb begin
    kt_ref_d   = kt_ref_q;
    ref_vld_d  = ref_vld_q;
    prev_d     = prev_q;
    prev_vld_d = prev_vld_q;
    seg_on_d   = seg_on_q;
    seg_ok_d   = seg_ok_q;
    if (hold) begin
      ref_vld_d = 1'b0;
    end else if (handoff) begin
      kt_ref_d  = kt_meas;
      ref_vld_d = 1'b1;
    end
    if (hold || !st_closed) begin
      prev_vld_d = 1'b0;
    end else if (comm_strobe) begin
      prev_d     = comm_per;
      prev_vld_d = 1'b1;
    end
    if (hold || st_idle) begin
      seg_on_d = 1'b0;
      seg_ok_d = 1'b0;
    end else if (elec_tick) begin
      seg_on_d = 1'b1;
      seg_ok_d = 1'b1;
    end else begin
      seg_ok_d = seg_ok_q && over;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kt_ref_q   <= '0;
      ref_vld_q  <= 1'b0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      seg_on_q   <= 1'b0;
      seg_ok_q   <= 1'b0;
    end else begin
      kt_ref_q   <= kt_ref_d;
      ref_vld_q  <= ref_vld_d;
      prev_q     <= prev_d;
      prev_vld_q <= prev_vld_d;
      seg_on_q   <= seg_on_d;
      seg_ok_q   <= seg_ok_d;
    end
  end

  p_window_blanked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blank_busy |-> !hit[3]);
  p_first_tick_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_on_q |-> !hit[5]);
endmodule

// File: rtl/lock_fault_ctl.sv
module lock_fault_ctl
  import lock_pkg::*;
#(
  parameter int RESTART_CYC = 1_250_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCHK-1:0] hit,
  output logic            lock_pulse,
  output logic [2:0]      cause,
  output logic            hiz_en,
  output logic            restart_req
);
  localparam int RW = (RESTART_CYC > 2) ? $clog2(RESTART_CYC) : 1;
  localparam logic [RW-1:0] LAST = RW'(RESTART_CYC - 1);

  logic [2:0]    sel;
  logic          fire, expire;
  logic [RW-1:0] cnt_q, cnt_d;
  logic          hiz_q, hiz_d, lock_q, lock_d, rst_q, rst_d;
  logic [2:0]    cause_q, cause_d;

  always_comb begin
    sel = CZ_NONE;
    for (int i = NCHK - 1; i >= 0; i--) begin
      if (hit[i]) sel = 3'(i + 1);
    end
  end

  assign fire   = (|hit) && !hiz_q;
  assign expire = hiz_q && (cnt_q == LAST);

  always_comb begin
    lock_d  = fire;
    rst_d   = expire;
    hiz_d   = hiz_q;
    cause_d = cause_q;
    cnt_d   = cnt_q;
    if (fire) begin
      hiz_d   = 1'b1;
      cause_d = sel;
      cnt_d   = '0;
    end else if (expire) begin
      hiz_d   = 1'b0;
      cause_d = CZ_NONE;
    end else if (hiz_q) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      rst_q   <= 1'b0;
      hiz_q   <= 1'b0;
      cause_q <= CZ_NONE;
      cnt_q   <= '0;
    end else begin
      lock_q  <= lock_d;
      rst_q   <= rst_d;
      hiz_q   <= hiz_d;
      cause_q <= cause_d;
      cnt_q   <= cnt_d;
    end
  end

  assign lock_pulse  = lock_q;
  assign restart_req = rst_q;
  assign hiz_en      = hiz_q;
  assign cause       = cause_q;

  p_lock_enters_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse |-> hiz_en);
  p_restart_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> (!hiz_en && cause == 3'd0));
  p_cause_present_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_en |-> (cause != 3'd0));
  p_cause_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_en && !lock_pulse) |-> $stable(cause));
  p_no_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_en |=> !lock_pulse);
endmodule

// File: rtl/lock_supervisor.sv
module lock_supervisor
  import lock_pkg::*;
#(
  parameter int KT_W        = 10,
  parameter int IU_W        = 10,
  parameter int FQ_W        = 12,
  parameter int PER_W       = 16,
  parameter int V_W         = 12,
  parameter int KT_MIN_MVHZ = 200,
  parameter int IU_MIN_MA   = 50,
  parameter int OL_MAX_HZ   = 200,
  parameter int BLANK_CYC   = 75_000_000,
  parameter int RESTART_CYC = 1_250_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ctl_state,
  input  logic             align_done,
  input  logic [IU_W-1:0]  iu_ma,
  input  logic             handoff,
  input  logic [KT_W-1:0]  kt_meas,
  input  logic [KT_W-1:0]  kt_run,
  input  logic [FQ_W-1:0]  comm_freq,
  input  logic             comm_strobe,
  input  logic [PER_W-1:0] comm_per,
  input  logic [V_W-1:0]   bemf,
  input  logic [V_W-1:0]   vph_u,
  input  logic             elec_tick,
  output logic             lock_pulse,
  output logic [2:0]       cause,
  output logic             hiz_en,
  output logic             restart_req
);
  logic [NCHK-1:0] hit;

  lock_criteria #(
    .KT_W(KT_W), .IU_W(IU_W), .FQ_W(FQ_W), .PER_W(PER_W), .V_W(V_W),
    .KT_MIN_MVHZ(KT_MIN_MVHZ), .IU_MIN_MA(IU_MIN_MA),
    .OL_MAX_HZ(OL_MAX_HZ), .BLANK_CYC(BLANK_CYC)
  ) u_crit (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (hiz_en),
    .ctl_state   (ctl_state),
    .align_done  (align_done),
    .iu_ma       (iu_ma),
    .handoff     (handoff),
    .kt_meas     (kt_meas),
    .kt_run      (kt_run),
    .comm_freq   (comm_freq),
    .comm_strobe (comm_strobe),
    .comm_per    (comm_per),
    .bemf        (bemf),
    .vph_u       (vph_u),
    .elec_tick   (elec_tick),
    .hit         (hit)
  );

  lock_fault_ctl #(.RESTART_CYC(RESTART_CYC)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit),
    .lock_pulse  (lock_pulse),
    .cause       (cause),
    .hiz_en      (hiz_en),
    .restart_req (restart_req)
  );

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!lock_pulse && !hiz_en && !restart_req));
endmodule

// File: tb/test_lock_supervisor.sv
module test_lock_supervisor;
  localparam int BC = 20;
  localparam int RC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctl_state = 2'd0;
  logic        align_done = 1'b0;
  logic [9:0]  iu_ma = '0;
  logic        handoff = 1'b0;
  logic [9:0]  kt_meas = '0;
  logic [9:0]  kt_run = '0;
  logic [11:0] comm_freq = '0;
  logic        comm_strobe = 1'b0;
  logic [15:0] comm_per = '0;
  logic [11:0] bemf = '0;
  logic [11:0] vph_u = '0;
  logic        elec_tick = 1'b0;
  logic        lock_pulse, hiz_en, restart_req;
  logic [2:0]  cause;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  lock_supervisor #(.BLANK_CYC(BC), .RESTART_CYC(RC)) i_lock_supervisor (
    .clk(clk), .rst_n(rst_n), .ctl_state(ctl_state), .align_done(align_done),
    .iu_ma(iu_ma), .handoff(handoff), .kt_meas(kt_meas), .kt_run(kt_run),
    .comm_freq(comm_freq), .comm_strobe(comm_strobe), .comm_per(comm_per),
    .bemf(bemf), .vph_u(vph_u), .elec_tick(elec_tick),
    .lock_pulse(lock_pulse), .cause(cause), .hiz_en(hiz_en),
    .restart_req(restart_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input string req);
    chk(!hiz_en && !lock_pulse, req, {30'd0, hiz_en, lock_pulse}, 0);
  endtask

  // Monitor: pops the expected cause for every lock and judges the wait.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && lock_pulse) begin
        int  held;
        bit  bad;
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected lock", int'(cause), 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(cause) == e, "R8 cause code", int'(cause), e);
        end
        held = int'(cause);
        bad  = 0;
        for (int k = 1; k < RC; k++) begin
          @(negedge clk);
          if (!hiz_en || lock_pulse || int'(cause) != held || restart_req) bad = 1;
        end
        chk(!bad, "R9 hiz held, no relock, cause frozen", int'(bad), 0);
        @(negedge clk);
        chk(restart_req && !hiz_en && cause == 3'd0, "R7 restart after wait",
            {29'd0, restart_req, hiz_en, |cause}, 4);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "R7 watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk(!lock_pulse && !hiz_en && !restart_req && cause == 3'd0, "R10 reset state",
        {28'd0, lock_pulse, hiz_en, restart_req, |cause}, 0);
    rst_n = 1'b1;
    tick(2);
    quiet("R10 idle after reset");

    // R2: alignment current
    ctl_state = 2'd1; iu_ma = 10'd51; align_done = 1'b1; tick(1);
    align_done = 1'b0; tick(3);
    quiet("R2 51 mA passes");
    iu_ma = 10'd50; exp_q.push_back(2); align_done = 1'b1; tick(1);
    align_done = 1'b0; tick(RC + 4);

    // R1: constant at handoff
    ctl_state = 2'd2; comm_freq = 12'd100; kt_meas = 10'd200; kt_run = 10'd200;
    handoff = 1'b1; tick(1);
    handoff = 1'b0; ctl_state = 2'd3; tick(3);
    quiet("R1 200 passes");
    ctl_state = 2'd2; kt_meas = 10'd199; exp_q.push_back(1);
    handoff = 1'b1; tick(1);
    handoff = 1'b0; tick(RC + 4);

    // R3: open-loop overspeed, with R9 stimulus during the wait
    comm_freq = 12'd200; tick(5);
    quiet("R3 200 Hz passes");
    ctl_state = 2'd3; comm_freq = 12'd250; tick(5);
    quiet("R3 not armed in closed loop");
    ctl_state = 2'd2; comm_freq = 12'd201; exp_q.push_back(3); tick(RC / 2);
    iu_ma = 10'd0; align_done = 1'b1; tick(1);
    align_done = 1'b0; tick(RC / 2 - 4);
    comm_freq = 12'd0; tick(10);
    quiet("R9 no relock after restart");

    // R4: running constant window with blanking
    ctl_state = 2'd2; comm_freq = 12'd100; kt_meas = 10'd300; kt_run = 10'd149;
    handoff = 1'b1; tick(1);
    handoff = 1'b0; ctl_state = 2'd3; tick(BC);
    quiet("R4 blanked after handoff");
    exp_q.push_back(4); tick(RC + 4);
    ctl_state = 2'd2; kt_run = 10'd150; handoff = 1'b1; tick(1);
    handoff = 1'b0; ctl_state = 2'd3; tick(BC + 5);
    quiet("R4 half of reference in window");
    kt_run = 10'd600; tick(3);
    quiet("R4 twice reference in window");
    kt_run = 10'd601; exp_q.push_back(4); tick(RC + 4);

    // R5: period collapse
    ctl_state = 2'd2; kt_run = 10'd300; handoff = 1'b1; tick(1);
    handoff = 1'b0; ctl_state = 2'd3;
    comm_per = 16'd100; comm_strobe = 1'b1; tick(1); comm_strobe = 1'b0; tick(2);
    comm_per = 16'd50;  comm_strobe = 1'b1; tick(1); comm_strobe = 1'b0; tick(3);
    quiet("R5 exactly half passes");
    comm_per = 16'd24; exp_q.push_back(5);
    comm_strobe = 1'b1; tick(1); comm_strobe = 1'b0; tick(RC + 4);

    // R6: back-EMF over a full electrical period
    vph_u = 12'd100; bemf = 12'd151;
    elec_tick = 1'b1; tick(1); elec_tick = 1'b0; tick(3);
    quiet("R6 first tick never fires");
    bemf = 12'd150; tick(1); bemf = 12'd151; tick(2);
    elec_tick = 1'b1; tick(1); elec_tick = 1'b0; tick(4);
    quiet("R6 dip cancels period");
    exp_q.push_back(6);
    elec_tick = 1'b1; tick(1); elec_tick = 1'b0; bemf = 12'd0; tick(RC + 4);

    // R8: two checks in one cycle, lowest code wins
    ctl_state = 2'd2; comm_freq = 12'd201; iu_ma = 10'd0; align_done = 1'b1;
    exp_q.push_back(2); tick(1);
    align_done = 1'b0; comm_freq = 12'd0; tick(RC + 4);

    tick(5);
    chk(exp_q.size() == 0, "R7 every expected lock seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule